// File: doc/BRIEF.md
# Timer Capture and Compare Channel Bank

This block sits next to a free-running 16-bit timer count and gives software a bank of event channels. Capture channels watch an input pin and, on the selected transition, record the count value in a register. Compare channels hold a match value written by software. When the count equals that value, the channel raises a one-cycle match pulse, sets a sticky flag and drives its output pin with a set, clear or toggle action.

There are three dedicated capture channels and four dedicated compare channels. One further channel is shared between the two roles. A control bit switches it at run time between a fourth capture channel and a fifth compare channel. Every capture and compare register comes out of reset holding all ones. Software reaches the bank through a simple register bus: writes are synchronous and reads are combinational from the address.

Register map: address 0 to 2 holds capture 1 to 3, address 3 the shared channel, address 4 to 7 compare 1 to 4, address 8 the control word, address 9 the pin actions and address 10 the compare flags.

Top module: `capcmp_timer`

## Requirements
- R1: Each capture channel i (0 to 2 dedicated, 3 shared) has a 2-bit edge select in control word bits [2i+2:2i+1]. The codes are 00 off, 01 rising, 10 falling and 11 either edge. Each pin passes two synchronizing flops, so the register loads the count present at the third rising clock edge after the pin changes.
- R2: Bus writes to the capture registers at addresses 0 to 2 are ignored.
- R3: After reset, every capture and compare register (addresses 0 to 7) reads 0xFFFF. The control word, pin actions and flags read 0, and cmpPin and cmpMatch are low.
- R4: The compare registers at addresses 4 to 7 (compare 1 to 4) and, in compare mode, the shared register at address 3 (compare 5) can be written and read back.
- R5: Control word bit 0 sets the role of the shared channel: 0 makes it compare channel 5 (cmpMatch[4], cmpPin[4], flag bit 4) and 1 makes it capture channel 4 on capPin[3]. Pin transitions on capPin[3] do not load the shared register in compare mode.
- R6: cmpMatch[k] is high during the cycle after a clock edge at which the count equals compare register k. The same edge sets flag bit k at address 10, and the flag stays set. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R7: Pin action field k at address 9, bits [2k+1:2k], selects what a match does: 00 none, 01 toggle, 10 clear, 11 set. The action takes effect on cmpPin[k] one clock edge after the match edge. Without a match, the pin holds its value.
- R8: In capture mode the shared channel ignores bus writes to address 3. It raises no match pulse, sets no flag and does not change cmpPin[4].
- R9: Reads of addresses 11 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timerCount | input | 16 | Free-running timer count |
| capPin | input | 4 | Capture pins; bit 3 feeds the shared channel |
| busAddr | input | 4 | Register address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Combinational read data |
| cmpMatch | output | 5 | One-cycle match pulses, compare 1 to 5 |
| cmpPin | output | 5 | Compare output pins |

## Verification
The hardest situation to reach is the shared channel holding a compare value that the count is about to pass while the channel is in capture mode. A capture can only load past count values, so this state cannot arise from capture events. The stimulus reaches it by writing a future match value in compare mode and then switching the role bit before the count arrives. The bench then watches the match pulse, the flag and the pin stay quiet. Random capture sequences also toggle the shared pin while it is in compare mode, to show that no capture occurs there.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  parameter int CNT_W     = 16;
  parameter int N_CAP_DED = 3;
  parameter int N_CMP_DED = 4;
  parameter int ADDR_W    = 4;

  localparam int N_CAP      = N_CAP_DED + 1;
  localparam int N_CMP      = N_CMP_DED + 1;
  localparam int SHARED_CAP = N_CAP - 1;
  localparam int SHARED_CMP = N_CMP - 1;

  localparam int ADDR_CAP0   = 0;
  localparam int ADDR_SHARED = N_CAP_DED;
  localparam int ADDR_CMP0   = ADDR_SHARED + 1;
  localparam int ADDR_CTRL   = ADDR_CMP0 + N_CMP_DED;
  localparam int ADDR_ACT    = ADDR_CTRL + 1;
  localparam int ADDR_FLAG   = ADDR_ACT + 1;

  localparam int CTRL_BITS = 1 + 2 * N_CAP;
  localparam int ACT_BITS  = 2 * N_CMP;

  typedef enum logic [1:0] {EDGE_OFF, EDGE_RISE, EDGE_FALL, EDGE_BOTH} edgeSel_e;
  typedef enum logic [1:0] {ACT_NONE, ACT_TOGGLE, ACT_CLEAR, ACT_SET} pinAct_e;

  typedef struct packed {
    logic [N_CAP-1:0] capLoad;
    logic [N_CMP-1:0] cmpWr;
    logic [N_CMP-1:0] flagClr;
    logic [CNT_W-1:0] wrData;
  } strobes_t;

  typedef struct packed {
    logic                  sharedCap;
    logic [N_CMP-1:0][1:0] act;
  } cfg_t;
endpackage

// File: rtl/capcmp_edge_det.sv
module capcmp_edge_det
  import capcmp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinIn,
  input  logic [1:0] sel,
  output logic       hit
);
  logic syncA, syncB, syncPrev;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncA    <= pinIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign rise = syncB & ~syncPrev;
  assign fall = ~syncB & syncPrev;

  always_comb begin
    case (edgeSel_e'(sel))
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/capcmp_ctrl.sv
module capcmp_ctrl
  import capcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_CAP-1:0]  capPin,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [CNT_W-1:0]  busWrData,
  output strobes_t          strb,
  output cfg_t              cfg,
  output logic [CNT_W-1:0]  ctrlWord,
  output logic [CNT_W-1:0]  actWord
);
  logic                  sharedCapQ;
  logic [N_CAP-1:0][1:0] edgeSelQ;
  logic [N_CMP-1:0][1:0] actQ;
  logic [N_CAP-1:0]      hit;
  logic                  wrCtrl, wrAct, wrFlag;

  assign wrCtrl = busWrEn && (busAddr == ADDR_W'(ADDR_CTRL));
  assign wrAct  = busWrEn && (busAddr == ADDR_W'(ADDR_ACT));
  assign wrFlag = busWrEn && (busAddr == ADDR_W'(ADDR_FLAG));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sharedCapQ <= 1'b0;
      edgeSelQ   <= '0;
      actQ       <= '0;
    end else begin
      if (wrCtrl) begin
        sharedCapQ <= busWrData[0];
        edgeSelQ   <= busWrData[CTRL_BITS-1:1];
      end
      if (wrAct) actQ <= busWrData[ACT_BITS-1:0];
    end
  end

  for (genvar i = 0; i < N_CAP; i++) begin : g_edge
    capcmp_edge_det u_edge (
      .clk   (clk),
      .rstN  (rstN),
      .pinIn (capPin[i]),
      .sel   (edgeSelQ[i]),
      .hit   (hit[i])
    );
  end

  always_comb begin
    strb.wrData  = busWrData;
    strb.flagClr = wrFlag ? busWrData[N_CMP-1:0] : '0;
    for (int i = 0; i < N_CAP_DED; i++) strb.capLoad[i] = hit[i];
    strb.capLoad[SHARED_CAP] = hit[SHARED_CAP] & sharedCapQ;
    for (int k = 0; k < N_CMP_DED; k++)
      strb.cmpWr[k] = busWrEn && (busAddr == ADDR_W'(ADDR_CMP0 + k));
    strb.cmpWr[SHARED_CMP] = busWrEn && (busAddr == ADDR_W'(ADDR_SHARED)) && !sharedCapQ;
  end

  assign cfg.sharedCap = sharedCapQ;
  assign cfg.act       = actQ;
  assign ctrlWord      = CNT_W'({edgeSelQ, sharedCapQ});
  assign actWord       = CNT_W'(actQ);
endmodule

// File: rtl/capcmp_datapath.sv
module capcmp_datapath
  import capcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  timerCount,
  input  strobes_t          strb,
  input  cfg_t              cfg,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  ctrlWord,
  input  logic [CNT_W-1:0]  actWord,
  output logic [CNT_W-1:0]  busRdData,
  output logic [N_CMP-1:0]  cmpMatch,
  output logic [N_CMP-1:0]  cmpPin
);
  logic [N_CAP_DED-1:0][CNT_W-1:0] capReg;
  logic [N_CMP_DED-1:0][CNT_W-1:0] cmpReg;
  logic [CNT_W-1:0]                sharedReg;
  logic [N_CMP-1:0][CNT_W-1:0]     cmpVal;
  logic [N_CMP-1:0]                matchNow, matchQ, flagQ, pinQ;

  for (genvar i = 0; i < N_CAP_DED; i++) begin : g_cap
    always_ff @(posedge clk) begin
      if (!rstN)                capReg[i] <= '1;
      else if (strb.capLoad[i]) capReg[i] <= timerCount;
    end
  end

  for (genvar k = 0; k < N_CMP_DED; k++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rstN)              cmpReg[k] <= '1;
      else if (strb.cmpWr[k]) cmpReg[k] <= strb.wrData;
    end
    assign cmpVal[k]   = cmpReg[k];
    assign matchNow[k] = (cmpReg[k] == timerCount);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                           sharedReg <= '1;
    else if (strb.capLoad[SHARED_CAP])   sharedReg <= timerCount;
    else if (strb.cmpWr[SHARED_CMP])     sharedReg <= strb.wrData;
  end
  assign cmpVal[SHARED_CMP]   = sharedReg;
  assign matchNow[SHARED_CMP] = (sharedReg == timerCount) && !cfg.sharedCap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchQ <= '0;
      flagQ  <= '0;
    end else begin
      matchQ <= matchNow;
      flagQ  <= (flagQ & ~strb.flagClr) | matchNow;
    end
  end

  for (genvar k = 0; k < N_CMP; k++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rstN) pinQ[k] <= 1'b0;
      else if (matchQ[k]) begin
        case (pinAct_e'(cfg.act[k]))
          ACT_TOGGLE: pinQ[k] <= ~pinQ[k];
          ACT_CLEAR:  pinQ[k] <= 1'b0;
          ACT_SET:    pinQ[k] <= 1'b1;
          default:    pinQ[k] <= pinQ[k];
        endcase
      end
    end
  end

  always_comb begin
    busRdData = '0;
    for (int i = 0; i < N_CAP_DED; i++)
      if (busAddr == ADDR_W'(ADDR_CAP0 + i)) busRdData = capReg[i];
    for (int k = 0; k < N_CMP_DED; k++)
      if (busAddr == ADDR_W'(ADDR_CMP0 + k)) busRdData = cmpVal[k];
    if (busAddr == ADDR_W'(ADDR_SHARED)) busRdData = sharedReg;
    if (busAddr == ADDR_W'(ADDR_CTRL))   busRdData = ctrlWord;
    if (busAddr == ADDR_W'(ADDR_ACT))    busRdData = actWord;
    if (busAddr == ADDR_W'(ADDR_FLAG))   busRdData = CNT_W'(flagQ);
  end

  assign cmpMatch = matchQ;
  assign cmpPin   = pinQ;
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import capcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  timerCount,
  input  logic [N_CAP-1:0]  capPin,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [CNT_W-1:0]  busWrData,
  output logic [CNT_W-1:0]  busRdData,
  output logic [N_CMP-1:0]  cmpMatch,
  output logic [N_CMP-1:0]  cmpPin
);
  strobes_t         strb;
  cfg_t             cfg;
  logic [CNT_W-1:0] ctrlWord, actWord;

  capcmp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .capPin    (capPin),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .strb      (strb),
    .cfg       (cfg),
    .ctrlWord  (ctrlWord),
    .actWord   (actWord)
  );

  capcmp_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .timerCount (timerCount),
    .strb       (strb),
    .cfg        (cfg),
    .busAddr    (busAddr),
    .ctrlWord   (ctrlWord),
    .actWord    (actWord),
    .busRdData  (busRdData),
    .cmpMatch   (cmpMatch),
    .cmpPin     (cmpPin)
  );
endmodule

// File: rtl/capcmp_checker.sv
module capcmp_checker
  import capcmp_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input strobes_t         strb,
  input cfg_t             cfg,
  input logic [N_CMP-1:0] cmpMatch,
  input logic [N_CMP-1:0] cmpPin
);
  p_no_cap_in_cmp_mode_r5: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.sharedCap |-> !strb.capLoad[SHARED_CAP]);

  p_no_write_in_cap_mode_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfg.sharedCap |-> !strb.cmpWr[SHARED_CMP]);

  p_shared_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.sharedCap && $past(cfg.sharedCap)) |-> !cmpMatch[SHARED_CMP]);

  for (genvar k = 0; k < N_CMP; k++) begin : g_pin_chk
    p_pin_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
      !cmpMatch[k] |=> $stable(cmpPin[k]));
    p_pin_toggle_r7: assert property (@(posedge clk) disable iff (!rstN)
      (cmpMatch[k] && cfg.act[k] == ACT_TOGGLE) |=> (cmpPin[k] != $past(cmpPin[k])));
    p_pin_set_r7: assert property (@(posedge clk) disable iff (!rstN)
      (cmpMatch[k] && cfg.act[k] == ACT_SET) |=> cmpPin[k]);
    p_pin_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
      (cmpMatch[k] && cfg.act[k] == ACT_CLEAR) |=> !cmpPin[k]);
  end
endmodule

bind capcmp_timer capcmp_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .strb     (strb),
  .cfg      (cfg),
  .cmpMatch (cmpMatch),
  .cmpPin   (cmpPin)
);

// File: tb/capcmp_timer_tb.sv
module capcmp_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cnt;
  logic [3:0]  capPin = '0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic [4:0]  cmpMatch, cmpPin;

  int checks = 0;
  int errors = 0;

  logic [15:0] capModel [4];
  logic [1:0]  edgeModel [4];
  logic [4:0]  pinModel;
  logic        sharedCapModel;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rstN) cnt <= '0;
    else       cnt <= cnt + 16'd1;
  end

  capcmp_timer u_dut (
    .clk(clk), .rstN(rstN), .timerCount(cnt), .capPin(capPin),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .cmpMatch(cmpMatch), .cmpPin(cmpPin)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  function automatic bit edgeHit(input logic [1:0] sel, input logic oldV, input logic newV);
    case (sel)
      2'b01:   return !oldV && newV;
      2'b10:   return oldV && !newV;
      2'b11:   return oldV != newV;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic applyAct(input logic [1:0] a, input logic p);
    case (a)
      2'b01:   return ~p;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return p;
    endcase
  endfunction

  function automatic logic [15:0] ctrlValue();
    return {7'd0, edgeModel[3], edgeModel[2], edgeModel[1], edgeModel[0], sharedCapModel};
  endfunction

  // R1 / R5: toggle one capture pin and compare against the model
  task automatic capStep(input int ch);
    logic        oldV, newV;
    logic [15:0] sampled, rd;
    bit          loads;
    oldV = capPin[ch];
    newV = ~oldV;
    @(negedge clk);
    capPin[ch] = newV;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    #1 sampled = cnt;
    @(posedge clk);
    loads = edgeHit(edgeModel[ch], oldV, newV) && (ch < 3 || sharedCapModel);
    if (loads) capModel[ch] = sampled;
    busRead(4'(ch), rd);
    chk(rd == capModel[ch], (ch == 3 && !sharedCapModel) ? "R5 shared capture ignored" : "R1 capture value", rd, capModel[ch]);
  endtask

  // R6 / R7: arm compare channel k and watch the window cycle by cycle
  task automatic cmpWindow(input int k, input logic [1:0] act);
    logic [15:0] val, rd;
    logic [4:0]  expVec;
    bit          pend, bad;
    logic [3:0]  addr;
    addr = (k == 4) ? 4'd3 : 4'(4 + k);
    busWrite(4'd9, 16'(act) << (2 * k));
    val = cnt + 16'd12 + 16'($urandom_range(0, 15));
    busWrite(addr, val);
    busRead(addr, rd);
    chk(rd == val, "R4 compare readback", rd, val);
    pend = 1'b0; bad = 1'b0;
    for (int j = 0; j < 45; j++) begin
      @(negedge clk);
      #1;
      if (pend) pinModel[k] = applyAct(act, pinModel[k]);
      pend = ((cnt - 16'd1) == val);
      expVec = pend ? (5'd1 << k) : 5'd0;
      if (cmpMatch != expVec) begin
        bad = 1'b1;
        $display("FAIL R6 match pulse ch%0d actual=%h expected=%h", k, cmpMatch, expVec);
      end
      if (cmpPin != pinModel) begin
        bad = 1'b1;
        $display("FAIL R7 pin action ch%0d actual=%h expected=%h", k, cmpPin, pinModel);
      end
    end
    checks++;
    if (bad) errors++;
    busRead(4'd10, rd);
    chk(rd == (16'd1 << k), "R6 flag set", rd, 16'd1 << k);
    busWrite(4'd10, 16'd0);
    busRead(4'd10, rd);
    chk(rd == (16'd1 << k), "R6 zero write keeps flag", rd, 16'd1 << k);
    busWrite(4'd10, 16'd1 << k);
    busRead(4'd10, rd);
    chk(rd == 16'd0, "R6 flag cleared", rd, 16'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rd, hold;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin capModel[i] = 16'hFFFF; edgeModel[i] = 2'b00; end
    pinModel = '0;
    sharedCapModel = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R3: reset state
    for (int a = 0; a < 8; a++) begin
      busRead(4'(a), rd);
      chk(rd == 16'hFFFF, "R3 register reset", rd, 16'hFFFF);
    end
    for (int a = 8; a < 11; a++) begin
      busRead(4'(a), rd);
      chk(rd == 16'h0000, "R3 control reset", rd, 16'h0000);
    end
    chk(cmpPin == 5'd0 && cmpMatch == 5'd0, "R3 outputs low", {cmpPin, cmpMatch}, 16'd0);

    // R9: unused addresses
    for (int a = 11; a < 16; a++) begin
      busRead(4'(a), rd);
      chk(rd == 16'h0000, "R9 unused read", rd, 16'h0000);
    end

    // R2: capture registers ignore writes
    for (int a = 0; a < 3; a++) begin
      busWrite(4'(a), 16'h1234);
      busRead(4'(a), rd);
      chk(rd == 16'hFFFF, "R2 capture write ignored", rd, 16'hFFFF);
    end

    // R1 directed: each edge code on channel 0
    for (int s = 0; s < 4; s++) begin
      edgeModel[0] = 2'(s);
      busWrite(4'd8, ctrlValue());
      capStep(0);
      capStep(0);
    end

    // R1 / R5 random: dedicated channels plus the shared pin in compare mode
    for (int it = 0; it < 40; it++) begin
      if (it % 8 == 0) begin
        for (int i = 0; i < 4; i++) edgeModel[i] = 2'($urandom_range(0, 3));
        edgeModel[3] = 2'b11;
        busWrite(4'd8, ctrlValue());
        busRead(4'd8, rd);
        chk(rd == ctrlValue(), "R5 control readback", rd, ctrlValue());
      end
      capStep($urandom_range(0, 3));
    end

    // R6 / R7: every compare channel with each action
    for (int k = 0; k < 5; k++) begin
      cmpWindow(k, 2'b01);
      cmpWindow(k, 2'($urandom_range(0, 3)));
    end
    cmpWindow(2, 2'b11);
    cmpWindow(2, 2'b10);
    cmpWindow(1, 2'b00);

    // R8: arm the shared compare, then switch to capture mode before the count arrives
    hold = cnt + 16'd20;
    busWrite(4'd3, hold);
    busWrite(4'd9, 16'b01 << 8);
    sharedCapModel = 1'b1;
    edgeModel[3] = 2'b01;
    busWrite(4'd8, ctrlValue());
    begin
      bit quiet;
      logic [4:0] pinHold;
      quiet = 1'b1;
      pinHold = cmpPin;
      for (int j = 0; j < 40; j++) begin
        @(negedge clk);
        #1;
        if (cmpMatch[4] || cmpPin != pinHold) quiet = 1'b0;
      end
      chk(quiet, "R8 shared compare idle", {11'd0, cmpMatch}, 16'd0);
    end
    busRead(4'd10, rd);
    chk(rd == 16'd0, "R8 shared flag idle", rd, 16'd0);
    busRead(4'd3, rd);
    chk(rd == hold, "R8 shared value kept", rd, hold);
    busWrite(4'd3, 16'h5A5A);
    busRead(4'd3, rd);
    chk(rd == hold, "R8 shared write ignored", rd, hold);
    capModel[3] = hold;
    if (capPin[3]) capStep(3);
    capStep(3);
    capStep(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule